// File: doc/BRIEF.md
# Paged Program Counter with Circular Return Stack

This unit produces the instruction address for a small 8-bit controller that fetches 14-bit instructions. It keeps a 13-bit program counter and a 5-bit upper-address latch. Every instruction cycle the counter either steps forward by one or is reloaded. A reload comes from an interrupt vector, from a jump or call target, from a return address, or from an ALU result written to the low address byte. The upper counter bits come from the latch, and the number of latch bits used depends on the kind of load.

Return addresses sit in an eight-entry circular stack. A call or an interrupt pushes to it, and any of three return strobes pops from it. The stack cannot be read or written by software, and it raises no overflow or underflow flag. Decode logic outside the unit sends one strobe per operation. When several strobes arrive in the same cycle, a fixed priority chooses one of them.

Top module: `pc_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` and `latch_o` are 0 and every stack entry is cleared. A return right after reset therefore loads 0x0000.
- R2: When no strobe is active, `pc_o` rises by one each cycle and wraps from 0x1FFF to 0x0000.
- R3: A write to the low byte (`pcl_we_i`) loads `alu_res_i` into `pc_o[7:0]` and all 5 latch bits into `pc_o[12:8]`. The latch value used is the one held before that edge.
- R4: A jump or call loads `target_i` into `pc_o[10:0]` and latch bits [4:3] into `pc_o[12:11]`. Latch bits [2:0] have no effect.
- R5: A call or an interrupt pushes the current `pc_o` plus one, taken modulo 2^13. A jump pushes nothing.
- R6: `ret_i`, `retlw_i` and `retfie_i` each pop. A pop loads all 13 bits of `pc_o` from the most recent stack entry.
- R7: The stack holds 8 entries and wraps. After nine pushes the ninth overwrites the first. Nine pops then return pushes 9, 8, ..., 2 and after that push 9 again. Popping an empty stack returns the stale entry the pointer reaches.
- R8: `latch_o` changes only one cycle after `latch_we_i` and then holds `latch_d_i`. Pushes and pops leave it unchanged.
- R9: Priority from highest to lowest is interrupt, call/jump, return, low-byte write, increment. Lower strobes in the same cycle have no effect.
- R10: An interrupt loads `pc_o` with the parameter `IRQ_VEC`, which defaults to 0x0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction-cycle clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| latch_we_i | input | 1 | Write strobe for the upper-address latch |
| latch_d_i | input | 5 | New latch value |
| pcl_we_i | input | 1 | ALU result written to low PC byte |
| alu_res_i | input | 8 | ALU result |
| jump_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe (push and jump) |
| target_i | input | 11 | Jump/call target field of the opcode |
| irq_i | input | 1 | Interrupt branch strobe (push and vector) |
| ret_i | input | 1 | Plain return strobe |
| retlw_i | input | 1 | Return-with-literal strobe |
| retfie_i | input | 1 | Return-from-interrupt strobe |
| pc_o | output | 13 | Program counter |
| latch_o | output | 5 | Upper-address latch |

## Verification
Some behaviour is checked on every cycle: each single-cycle load rule (increment with wrap, low-byte write, jump/call paging, interrupt vector), the rule that the latch changes only through its write port, and a call followed at once by a return landing on the address after the call. Only the bench scenarios can show the deeper stack behaviour. That covers the nine-push overwrite and its pop order, the stale entry seen on underflow, the stack being cleared by reset, and the ordering when several strobes are active together.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [2:0] {
    OP_INC,
    OP_PCL,
    OP_RET,
    OP_JMP,
    OP_CALL,
    OP_IRQ
  } pc_op_e;
endpackage

// File: rtl/pc_op_sel.sv
module pc_op_sel
  import pc_pkg::*;
(
  input  logic   irq_i,
  input  logic   call_i,
  input  logic   jump_i,
  input  logic   ret_i,
  input  logic   retlw_i,
  input  logic   retfie_i,
  input  logic   pcl_we_i,
  output pc_op_e op_o,
  output logic   push_o,
  output logic   pop_o
);
  logic any_ret;
  assign any_ret = ret_i | retlw_i | retfie_i;

  always_comb begin
    if (irq_i)                 op_o = OP_IRQ;
    else if (call_i)           op_o = OP_CALL;
    else if (jump_i)           op_o = OP_JMP;
    else if (any_ret)          op_o = OP_RET;
    else if (pcl_we_i)         op_o = OP_PCL;
    else                       op_o = OP_INC;
  end

  assign push_o = (op_o == OP_IRQ) || (op_o == OP_CALL);
  assign pop_o  = (op_o == OP_RET);
endmodule

// File: rtl/pc_ret_stack.sv
// Circular return stack; DEPTH must be a power of two so the pointer wraps naturally.
module pc_ret_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_d_i,
  output logic [W-1:0] top_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] rd_ptr;

  assign rd_ptr = ptr_q - PTR_W'(1);
  assign top_o  = mem_q[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (push_i) begin
      ptr_q <= ptr_q + PTR_W'(1);
    end else if (pop_i) begin
      ptr_q <= rd_ptr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= push_d_i;
    end
  end
endmodule

// File: rtl/pc_next.sv
module pc_next
  import pc_pkg::*;
#(
  parameter int              PC_W    = 13,
  parameter int              LOW_W   = 8,
  parameter int              TGT_W   = 11,
  parameter int              LATCH_W = 5,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004,
  localparam int             PAGE_W  = PC_W - TGT_W
) (
  input  pc_op_e             op_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [LATCH_W-1:0] latch_i,
  input  logic [LOW_W-1:0]   alu_res_i,
  input  logic [TGT_W-1:0]   target_i,
  input  logic [PC_W-1:0]    top_i,
  output logic [PC_W-1:0]    pc_inc_o,
  output logic [PC_W-1:0]    pc_d_o
);
  logic [PAGE_W-1:0] page;

  assign pc_inc_o = pc_i + PC_W'(1);
  assign page     = latch_i[LATCH_W-1 -: PAGE_W];

  always_comb begin
    unique case (op_i)
      OP_IRQ:          pc_d_o = IRQ_VEC;
      OP_CALL, OP_JMP: pc_d_o = {page, target_i};
      OP_RET:          pc_d_o = top_i;
      OP_PCL:          pc_d_o = {latch_i, alu_res_i};
      default:         pc_d_o = pc_inc_o;
    endcase
  end
endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import pc_pkg::*;
#(
  parameter int              PC_W    = 13,
  parameter int              LOW_W   = 8,
  parameter int              TGT_W   = 11,
  parameter int              LATCH_W = PC_W - LOW_W,
  parameter int              DEPTH   = 8,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               latch_we_i,
  input  logic [LATCH_W-1:0] latch_d_i,
  input  logic               pcl_we_i,
  input  logic [LOW_W-1:0]   alu_res_i,
  input  logic               jump_i,
  input  logic               call_i,
  input  logic [TGT_W-1:0]   target_i,
  input  logic               irq_i,
  input  logic               ret_i,
  input  logic               retlw_i,
  input  logic               retfie_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [LATCH_W-1:0] latch_o
);
  pc_op_e             op;
  logic               push, pop;
  logic [PC_W-1:0]    pc_q, pc_d, pc_inc, top;
  logic [LATCH_W-1:0] latch_q;

  pc_op_sel u_sel (
    .irq_i    (irq_i),
    .call_i   (call_i),
    .jump_i   (jump_i),
    .ret_i    (ret_i),
    .retlw_i  (retlw_i),
    .retfie_i (retfie_i),
    .pcl_we_i (pcl_we_i),
    .op_o     (op),
    .push_o   (push),
    .pop_o    (pop)
  );

  pc_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .pop_i    (pop),
    .push_d_i (pc_inc),
    .top_o    (top)
  );

  pc_next #(
    .PC_W(PC_W), .LOW_W(LOW_W), .TGT_W(TGT_W), .LATCH_W(LATCH_W), .IRQ_VEC(IRQ_VEC)
  ) u_next (
    .op_i      (op),
    .pc_i      (pc_q),
    .latch_i   (latch_q),
    .alu_res_i (alu_res_i),
    .target_i  (target_i),
    .top_i     (top),
    .pc_inc_o  (pc_inc),
    .pc_d_o    (pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         latch_q <= '0;
    else if (latch_we_i) latch_q <= latch_d_i;
  end

  assign pc_o    = pc_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/pc_unit_chk.sv
module pc_unit_chk #(
  parameter int              PC_W    = 13,
  parameter int              LOW_W   = 8,
  parameter int              TGT_W   = 11,
  parameter int              LATCH_W = PC_W - LOW_W,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004,
  localparam int             PAGE_W  = PC_W - TGT_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               latch_we_i,
  input logic [LATCH_W-1:0] latch_d_i,
  input logic               pcl_we_i,
  input logic [LOW_W-1:0]   alu_res_i,
  input logic               jump_i,
  input logic               call_i,
  input logic [TGT_W-1:0]   target_i,
  input logic               irq_i,
  input logic               ret_i,
  input logic               retlw_i,
  input logic               retfie_i,
  input logic [PC_W-1:0]    pc_o,
  input logic [LATCH_W-1:0] latch_o
);
  logic cj_win, ret_win, pcl_win, idle;
  assign cj_win  = !irq_i && (call_i || jump_i);
  assign ret_win = !irq_i && !call_i && !jump_i && (ret_i || retlw_i || retfie_i);
  assign pcl_win = !irq_i && !call_i && !jump_i && !(ret_i || retlw_i || retfie_i) && pcl_we_i;
  assign idle    = !irq_i && !call_i && !jump_i && !(ret_i || retlw_i || retfie_i) && !pcl_we_i;

  assert_pc_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> pc_o == PC_W'($past(pc_o) + PC_W'(1)));

  assert_pcl_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcl_win |=> pc_o == {$past(latch_o), $past(alu_res_i)});

  assert_jump_page_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cj_win |=> pc_o == {$past(latch_o[LATCH_W-1 -: PAGE_W]), $past(target_i)});

  assert_irq_vec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> pc_o == IRQ_VEC);

  assert_latch_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_we_i |=> $stable(latch_o));

  assert_latch_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_we_i |=> latch_o == $past(latch_d_i));

  assert_call_ret_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_win && $past(cj_win && call_i)) |=> pc_o == PC_W'($past(pc_o, 2) + PC_W'(1)));
endmodule

bind pc_unit pc_unit_chk #(
  .PC_W(PC_W), .LOW_W(LOW_W), .TGT_W(TGT_W), .LATCH_W(LATCH_W), .IRQ_VEC(IRQ_VEC)
) u_chk (.*);

// File: tb/tb_pc_unit.sv
module tb_pc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        latch_we = 0, pcl_we = 0, jump = 0, call = 0, irq = 0;
  logic        ret = 0, retlw = 0, retfie = 0;
  logic [4:0]  latch_d = '0;
  logic [7:0]  alu_res = '0;
  logic [10:0] target = '0;
  logic [12:0] pc;
  logic [4:0]  latch;
  int checks = 0, failures = 0;
  logic [12:0] pushv [1:9];

  always #10 clk = ~clk;

  pc_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .latch_we_i(latch_we), .latch_d_i(latch_d),
    .pcl_we_i(pcl_we), .alu_res_i(alu_res), .jump_i(jump), .call_i(call),
    .target_i(target), .irq_i(irq), .ret_i(ret), .retlw_i(retlw), .retfie_i(retfie),
    .pc_o(pc), .latch_o(latch)
  );

  // strobes: irq call jump ret retlw retfie pcl latch_we | latch_d | alu | target | expected pc
  localparam int N = 20;
  localparam logic [44:0] TBL [N] = '{
    {8'b00000000, 5'h00, 8'h00, 11'h000, 13'h0001},  // R2
    {8'b00000000, 5'h00, 8'h00, 11'h000, 13'h0002},  // R2
    {8'b00000001, 5'h1A, 8'h00, 11'h000, 13'h0003},  // R8 latch write, pc steps
    {8'b00000010, 5'h00, 8'h40, 11'h000, 13'h1A40},  // R3
    {8'b00000000, 5'h00, 8'h00, 11'h000, 13'h1A41},  // R2
    {8'b00100000, 5'h00, 8'h00, 11'h123, 13'h1923},  // R4 jump
    {8'b01000000, 5'h00, 8'h00, 11'h055, 13'h1855},  // R4/R5 call
    {8'b00000000, 5'h00, 8'h00, 11'h000, 13'h1856},
    {8'b10000000, 5'h00, 8'h00, 11'h000, 13'h0004},  // R10 irq
    {8'b00000000, 5'h00, 8'h00, 11'h000, 13'h0005},
    {8'b00000100, 5'h00, 8'h00, 11'h000, 13'h1857},  // R6 retfie
    {8'b00001000, 5'h00, 8'h00, 11'h000, 13'h1924},  // R6 retlw
    {8'b11000000, 5'h00, 8'h00, 11'h2AA, 13'h0004},  // R9 irq over call
    {8'b00010000, 5'h00, 8'h00, 11'h000, 13'h1925},  // R6 ret
    {8'b00010010, 5'h00, 8'h77, 11'h000, 13'h0000},  // R9/R7 ret over pcl, stale entry
    {8'b01010000, 5'h00, 8'h00, 11'h000, 13'h1800},  // R9 call over ret
    {8'b00010000, 5'h00, 8'h00, 11'h000, 13'h0001},  // R5 pushed pc+1
    {8'b00000011, 5'h00, 8'hFF, 11'h000, 13'h1AFF},  // R3 old latch used
    {8'b00000010, 5'h00, 8'h10, 11'h000, 13'h0010},  // R3 new latch
    {8'b00100010, 5'h00, 8'h33, 11'h7FF, 13'h07FF}   // R9 jump over pcl
  };

  task automatic set_in(input logic [7:0] s, input logic [4:0] ld, input logic [7:0] d,
                        input logic [10:0] t);
    {irq, call, jump, ret, retlw, retfie, pcl_we, latch_we} = s;
    latch_d = ld; alu_res = d; target = t;
  endtask

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] s, input logic [4:0] ld, input logic [7:0] d,
                     input logic [10:0] t);
    set_in(s, ld, d, t);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 pc", pc, 13'h0000);
    chk("R1 latch", {8'h00, latch}, 13'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      cyc(TBL[i][44:37], TBL[i][36:32], TBL[i][31:24], TBL[i][23:13]);
      chk($sformatf("table row %0d", i), pc, TBL[i][12:0]);
    end

    // R2 wrap, R4 low latch bits ignored
    cyc(8'b00000001, 5'h1F, 8'h00, 11'h000);
    cyc(8'b00000010, 5'h00, 8'hFF, 11'h000);
    chk("R3 full page", pc, 13'h1FFF);
    cyc(8'b00000000, 5'h00, 8'h00, 11'h000);
    chk("R2 wrap", pc, 13'h0000);
    cyc(8'b00100000, 5'h00, 8'h00, 11'h005);
    chk("R4 latch[2:0] ignored", pc, 13'h1805);

    // R7 circular overwrite: nine calls, nine returns
    for (int k = 1; k <= 9; k++) begin
      pushv[k] = pc + 13'd1;
      cyc(8'b01000000, 5'h00, 8'h00, 11'(k * 16));
    end
    chk("R8 latch after pushes", {8'h00, latch}, 13'h001F);
    for (int k = 9; k >= 2; k--) begin
      cyc(8'b00010000, 5'h00, 8'h00, 11'h000);
      chk($sformatf("R7 pop %0d", k), pc, pushv[k]);
    end
    cyc(8'b00001000, 5'h00, 8'h00, 11'h000);
    chk("R7 ninth pop wraps", pc, pushv[9]);
    chk("R8 latch after pops", {8'h00, latch}, 13'h001F);

    // R1 asynchronous reset mid-run clears pc, latch and stack
    set_in(8'b01000001, 5'h0C, 8'h00, 11'h111);
    #3 rst_n = 1'b0;
    #1;
    chk("R1 async pc", pc, 13'h0000);
    chk("R1 async latch", {8'h00, latch}, 13'h0000);
    @(negedge clk);
    set_in(8'b00010000, 5'h00, 8'h00, 11'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stack cleared", pc, 13'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule